// File: doc/BRIEF.md
# Decimating FIR MAC Cell Array

This block is a systolic FIR engine made of four multiply-accumulate cells in a chain. A registered input sample is broadcast to all four cells at once. Coefficients enter at the head of the chain and step from cell to cell. Between any two neighbouring cells, and between the last cell and the cascade output, the coefficient passes through a delay line whose length can be selected. A longer delay spaces the taps in time, so the same array produces outputs decimated by 1, 2, 3 or 4. The cascade output lets several arrays be joined to build longer filters.

Each cell multiplies the shared sample by its own coefficient, using an 8x8 product. The product is widened to 26 bits and either added to the cell's accumulator or loaded into it. A per-cell erase strobe chooses the load, which starts a new output sum. Two separate selects decide whether the data and the coefficients are read as unsigned or as two's complement. All four accumulators are exposed on one packed bus for a downstream output stage.

Top module: `fir_mac_array`

## Requirements
- R1: On a clock edge with `rst` high, all four accumulators, both input registers, every coefficient delay stage and `cout` become zero.
- R2: At a clock edge, the data register takes `din` when `data_en` is 1 and holds its value when `data_en` is 0. The cells use the registered value, so `din` captured at edge t first reaches an accumulator at edge t+1.
- R3: At a clock edge, the coefficient register takes `cin` when `coef_en` is 1 and holds its value when `coef_en` is 0. This register is the coefficient seen by cell 0.
- R4: Each cell forms the product of the registered data and its coefficient. The data is read as two's complement when `data_signed` is 1 and as unsigned when it is 0. The coefficient follows `coef_signed` in the same way. The product is extended to 26 bits, with the sign kept when the product is negative.
- R5: At a clock edge, accumulator k loads the product when `erase[k]` is 1 and adds the product to its value when `erase[k]` is 0.
- R6: A `dec_mode` value M (0 to 3) places M+1 register stages between the coefficient of cell k and the coefficient of cell k+1. A coefficient captured at edge 0, with data 1, first changes accumulator k at edge 1+k*(M+1).
- R7: `cout` is the coefficient of cell 3 after a further M+1 stages. A coefficient captured at edge 0 appears on `cout` after edge 4*(M+1).
- R8: Accumulators wrap modulo 2^26 with no saturation.
- R9: `acc_bus[26*k+25:26*k]` carries the accumulator of cell k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_en | input | 1 | Load enable for the data register |
| din | input | 8 | Input sample |
| data_signed | input | 1 | 1: data is two's complement, 0: unsigned |
| coef_en | input | 1 | Load enable for the coefficient register |
| cin | input | 8 | Coefficient input |
| coef_signed | input | 1 | 1: coefficients are two's complement, 0: unsigned |
| dec_mode | input | 2 | Decimation select; M gives M+1 delay stages per hop |
| erase | input | 4 | Per-cell strobe that loads the product instead of adding it |
| cout | output | 8 | Cascade coefficient output |
| acc_bus | output | 104 | Packed accumulators, cell k at bits 26k+25..26k |

## Verification
The bench builds the array with its default parameters: four cells, 8-bit operands, 26-bit accumulators and a four-stage coefficient delay. With these sizes a sustained 255 x 255 unsigned product wraps an accumulator after about a thousand cycles, so the wrap boundary can be reached in a short run. A single coefficient impulse measures the hop delay of every cell and of the cascade in all four decimation modes. All four signedness combinations are applied to both positive and negative operands. Pseudo-random streams are run in each mode, with erase strobes staggered across the cells.

// File: rtl/fir_arr_pkg.sv
package fir_arr_pkg;
  localparam int DATA_W     = 8;
  localparam int COEF_W     = 8;
  localparam int ACC_W      = 26;
  localparam int CELLS      = 4;
  localparam int DEC_STAGES = 4;

  // decimation select encodings: hop delay of 1..4 register stages
  typedef enum logic [1:0] {
    DEC_BY1 = 2'd0,
    DEC_BY2 = 2'd1,
    DEC_BY3 = 2'd2,
    DEC_BY4 = 2'd3
  } dec_mode_e;
endpackage

// File: rtl/fir_coef_delay.sv
module fir_coef_delay #(
  parameter int W      = 8,
  parameter int STAGES = 4,
  parameter int SEL_W  = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     d,
  output logic [W-1:0]     q
);
  logic [W-1:0] stg [STAGES];

  // stages shift every cycle; the select only chooses the tap
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  always_comb begin
    q = stg[STAGES-1];
    if (int'(sel) < STAGES) q = stg[sel];
  end
endmodule

// File: rtl/fir_mac_cell.sv
module fir_mac_cell #(
  parameter int DW     = 8,
  parameter int CW     = 8,
  parameter int AW     = 26,
  parameter int STAGES = 4,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    din,
  input  logic [CW-1:0]    coef_in,
  input  logic             data_signed,
  input  logic             coef_signed,
  input  logic             erase,
  input  logic [SEL_W-1:0] sel,
  output logic [CW-1:0]    coef_out,
  output logic [AW-1:0]    acc
);
  localparam int PW = DW + CW + 2;

  logic signed [DW:0]   a_ext;
  logic signed [CW:0]   b_ext;
  logic signed [PW-1:0] p_full;
  logic [AW-1:0]        prod;

  // one extra operand bit covers all four signedness pairings
  always_comb begin
    a_ext  = {data_signed & din[DW-1], din};
    b_ext  = {coef_signed & coef_in[CW-1], coef_in};
    p_full = a_ext * b_ext;
    prod   = {{(AW-PW){p_full[PW-1]}}, p_full};
  end

  always_ff @(posedge clk) begin
    if (rst)        acc <= '0;
    else if (erase) acc <= prod;
    else            acc <= acc + prod;
  end

  fir_coef_delay #(.W(CW), .STAGES(STAGES), .SEL_W(SEL_W)) u_dly (
    .clk (clk),
    .rst (rst),
    .sel (sel),
    .d   (coef_in),
    .q   (coef_out)
  );

  AST_ERASE_LOAD: assert property (@(posedge clk) disable iff (rst)
    erase |=> acc == $past(prod)) else $error("erase did not load product"); // R5
  AST_ACC_ADD: assert property (@(posedge clk) disable iff (rst)
    !erase |=> acc == $past(acc) + $past(prod)) else $error("accumulate mismatch"); // R5
  AST_UNSIGNED_NONNEG: assert property (@(posedge clk) disable iff (rst)
    (!data_signed && !coef_signed) |-> !prod[AW-1]) else $error("unsigned product negative"); // R4
  AST_SIGNED_SIGN: assert property (@(posedge clk) disable iff (rst)
    (data_signed && coef_signed && din != '0 && coef_in != '0)
      |-> prod[AW-1] == (din[DW-1] ^ coef_in[CW-1])) else $error("signed product sign"); // R4
endmodule

// File: rtl/fir_mac_array.sv
module fir_mac_array
  import fir_arr_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int CW     = COEF_W,
  parameter int AW     = ACC_W,
  parameter int NCELL  = CELLS,
  parameter int STAGES = DEC_STAGES,
  parameter int MODE_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_en,
  input  logic [DW-1:0]     din,
  input  logic              data_signed,
  input  logic              coef_en,
  input  logic [CW-1:0]     cin,
  input  logic              coef_signed,
  input  logic [MODE_W-1:0] dec_mode,
  input  logic [NCELL-1:0]  erase,
  output logic [CW-1:0]     cout,
  output logic [NCELL*AW-1:0] acc_bus
);
  logic [DW-1:0] din_q;
  logic [CW-1:0] cin_q;
  logic [CW-1:0] chain [NCELL+1];
  logic [AW-1:0] acc_w [NCELL];

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q <= '0;
      cin_q <= '0;
    end else begin
      if (data_en) din_q <= din;
      if (coef_en) cin_q <= cin;
    end
  end

  assign chain[0] = cin_q;
  assign cout     = chain[NCELL];

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    fir_mac_cell #(
      .DW(DW), .CW(CW), .AW(AW), .STAGES(STAGES), .SEL_W(MODE_W)
    ) u_cell (
      .clk         (clk),
      .rst         (rst),
      .din         (din_q),
      .coef_in     (chain[k]),
      .data_signed (data_signed),
      .coef_signed (coef_signed),
      .erase       (erase[k]),
      .sel         (dec_mode),
      .coef_out    (chain[k+1]),
      .acc         (acc_w[k])
    );
    assign acc_bus[k*AW +: AW] = acc_w[k];
  end

  // cycles since reset, saturating; guards the $past depth below
  logic [2:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)                age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc_bus == '0 && cout == '0)) else $error("reset state"); // R1
  AST_CASCADE_OUT: assert property (@(posedge clk) disable iff (rst)
    (dec_mode == DEC_BY1 && age_q >= 3'd1) |-> cout == $past(chain[NCELL-1])) else $error("cascade"); // R7

  for (genvar k = 0; k < NCELL; k++) begin : g_hop
    AST_HOP_M0: assert property (@(posedge clk) disable iff (rst)
      (dec_mode == DEC_BY1 && age_q >= 3'd1) |-> chain[k+1] == $past(chain[k], 1)) else $error("hop m0"); // R6
    AST_HOP_M1: assert property (@(posedge clk) disable iff (rst)
      (dec_mode == DEC_BY2 && age_q >= 3'd2) |-> chain[k+1] == $past(chain[k], 2)) else $error("hop m1"); // R6
    AST_HOP_M2: assert property (@(posedge clk) disable iff (rst)
      (dec_mode == DEC_BY3 && age_q >= 3'd3) |-> chain[k+1] == $past(chain[k], 3)) else $error("hop m2"); // R6
    AST_HOP_M3: assert property (@(posedge clk) disable iff (rst)
      (dec_mode == DEC_BY4 && age_q >= 3'd4) |-> chain[k+1] == $past(chain[k], 4)) else $error("hop m3"); // R6
  end
endmodule

// File: tb/sim_fir_mac_array.sv
`timescale 1ns/1ps
module sim_fir_mac_array;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_en = 1'b0, data_signed = 1'b0, coef_en = 1'b0, coef_signed = 1'b0;
  logic [7:0] din = '0, cin = '0;
  logic [1:0] dec_mode = '0;
  logic [3:0] erase = '0;
  logic [7:0] cout;
  logic [103:0] acc_bus;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fir_mac_array u0 (
    .clk(clk), .rst(rst), .data_en(data_en), .din(din), .data_signed(data_signed),
    .coef_en(coef_en), .cin(cin), .coef_signed(coef_signed), .dec_mode(dec_mode),
    .erase(erase), .cout(cout), .acc_bus(acc_bus)
  );

  // behavioural reference state
  logic [7:0]  m_din = '0, m_cin = '0;
  logic [7:0]  m_dl [4][4];
  logic [25:0] m_acc [4];

  logic [103:0] ea_q [$];
  logic [7:0]   ec_q [$];
  string        tag_q [$];

  function automatic logic [25:0] bprod(logic [7:0] d, logic [7:0] c, logic ds, logic cs);
    int a, b;
    a = ds ? int'($signed(d)) : int'(d);
    b = cs ? int'($signed(c)) : int'(c);
    return 26'(a * b);
  endfunction

  function automatic logic [25:0] acc_of(int k);
    return acc_bus[26*k +: 26];
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: apply one cycle, advance the reference, push the expectation
  task automatic step(logic den, logic [7:0] d, logic cen, logic [7:0] c,
                      logic ds, logic cs, logic [1:0] md, logic [3:0] er, string tag);
    logic [7:0] cn [4];
    @(negedge clk);
    data_en = den; din = d; coef_en = cen; cin = c;
    data_signed = ds; coef_signed = cs; dec_mode = md; erase = er;
    cn[0] = m_cin;
    for (int k = 1; k < 4; k++) cn[k] = m_dl[k-1][md];
    for (int k = 0; k < 4; k++) begin
      if (er[k]) m_acc[k] = bprod(m_din, cn[k], ds, cs);
      else       m_acc[k] = m_acc[k] + bprod(m_din, cn[k], ds, cs);
      for (int j = 3; j > 0; j--) m_dl[k][j] = m_dl[k][j-1];
      m_dl[k][0] = cn[k];
    end
    if (den) m_din = d;
    if (cen) m_cin = c;
    ea_q.push_back({m_acc[3], m_acc[2], m_acc[1], m_acc[0]});
    ec_q.push_back(m_dl[3][md]);
    tag_q.push_back(tag);
    @(posedge clk);
    #2;
  endtask

  // monitor: pop and compare once per edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (ea_q.size() > 0) begin
        logic [103:0] ea;
        logic [7:0] ec;
        string t;
        ea = ea_q.pop_front();
        ec = ec_q.pop_front();
        t  = tag_q.pop_front();
        for (int k = 0; k < 4; k++) chk({t, " R9 acc"}, 64'(acc_of(k)), 64'(ea[26*k +: 26]));
        chk({t, " R7 cout"}, 64'(cout), 64'(ec));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL ALL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    int first_nz [4];
    int cout_at;
    for (int k = 0; k < 4; k++) begin
      m_acc[k] = '0;
      for (int j = 0; j < 4; j++) m_dl[k][j] = '0;
    end
    repeat (3) @(posedge clk);
    #2;
    for (int k = 0; k < 4; k++) chk("R1 reset acc", 64'(acc_of(k)), 64'd0);
    chk("R1 reset cout", 64'(cout), 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // R4: signedness combinations, operands 0xFE and 0x03
    for (int i = 0; i < 8; i++) step(1, 8'hFE, 1, 8'h03, 1, 1, 0, 0, "R4 fill");
    step(1, 8'hFE, 1, 8'h03, 1, 1, 0, 4'hF, "R4");
    for (int k = 0; k < 4; k++) chk("R4 s*s -2*3", 64'(acc_of(k)), 64'(26'h3FFFFFA));
    step(1, 8'hFE, 1, 8'h03, 0, 1, 0, 4'hF, "R4");
    chk("R4 u*s 254*3", 64'(acc_of(0)), 64'd762);
    step(1, 8'hFE, 1, 8'h03, 0, 0, 0, 4'hF, "R4");
    chk("R4 u*u 254*3", 64'(acc_of(3)), 64'd762);
    // operands 0xFE and 0x83
    for (int i = 0; i < 8; i++) step(1, 8'hFE, 1, 8'h83, 1, 1, 0, 0, "R4 fill");
    step(1, 8'hFE, 1, 8'h83, 1, 1, 0, 4'hF, "R4");
    chk("R4 s*s -2*-125", 64'(acc_of(2)), 64'd250);
    step(1, 8'hFE, 1, 8'h83, 0, 0, 0, 4'hF, "R4");
    chk("R4 u*u 254*131", 64'(acc_of(1)), 64'd33274);
    step(1, 8'hFE, 1, 8'h83, 0, 1, 0, 4'hF, "R4");
    chk("R4 u*s 254*-125", 64'(acc_of(0)), 64'd67077114);
    step(1, 8'hFE, 1, 8'h83, 1, 0, 0, 4'hF, "R4");
    chk("R4 s*u -2*131", 64'(acc_of(3)), 64'd67108602);

    // R5: load then accumulate, per-cell erase
    for (int i = 0; i < 8; i++) step(1, 8'd3, 1, 8'd5, 0, 0, 0, 0, "R5 fill");
    step(1, 8'd3, 1, 8'd5, 0, 0, 0, 4'hF, "R5");
    for (int i = 0; i < 9; i++) step(1, 8'd3, 1, 8'd5, 0, 0, 0, 0, "R5");
    for (int k = 0; k < 4; k++) chk("R5 sum of ten", 64'(acc_of(k)), 64'd150);
    step(1, 8'd3, 1, 8'd5, 0, 0, 0, 4'b0101, "R5");
    chk("R5 R9 cell0 erased", 64'(acc_of(0)), 64'd15);
    chk("R5 R9 cell1 added", 64'(acc_of(1)), 64'd165);
    chk("R5 R9 cell2 erased", 64'(acc_of(2)), 64'd15);
    chk("R5 R9 cell3 added", 64'(acc_of(3)), 64'd165);

    // R2: data hold and one-edge latency
    for (int i = 0; i < 8; i++) step(1, 8'd7, 1, 8'd1, 0, 0, 0, 0, "R2 fill");
    step(0, 8'd100, 1, 8'd1, 0, 0, 0, 4'hF, "R2");
    step(0, 8'd100, 1, 8'd1, 0, 0, 0, 4'hF, "R2");
    chk("R2 data held", 64'(acc_of(0)), 64'd7);
    step(1, 8'd100, 1, 8'd1, 0, 0, 0, 4'hF, "R2");
    chk("R2 old data still used", 64'(acc_of(0)), 64'd7);
    step(1, 8'd100, 1, 8'd1, 0, 0, 0, 4'hF, "R2");
    chk("R2 new data used", 64'(acc_of(0)), 64'd100);

    // R3: coefficient hold
    step(1, 8'd100, 0, 8'd9, 0, 0, 0, 4'hF, "R3");
    step(1, 8'd100, 0, 8'd9, 0, 0, 0, 4'hF, "R3");
    chk("R3 coef held", 64'(acc_of(0)), 64'd100);

    // R6/R7: coefficient impulse timing in every mode
    for (int md = 0; md < 4; md++) begin
      for (int i = 0; i < 19; i++) step(1, 8'd1, 1, 8'd0, 0, 0, 2'(md), 0, "R6 flush");
      step(1, 8'd1, 1, 8'd0, 0, 0, 2'(md), 4'hF, "R6 flush");
      step(1, 8'd1, 1, 8'h5A, 0, 0, 2'(md), 0, "R6");
      for (int k = 0; k < 4; k++) first_nz[k] = -1;
      cout_at = -1;
      for (int i = 1; i <= 20; i++) begin
        step(1, 8'd1, 1, 8'd0, 0, 0, 2'(md), 0, "R6");
        for (int k = 0; k < 4; k++)
          if (first_nz[k] < 0 && acc_of(k) != 0) first_nz[k] = i;
        if (cout_at < 0 && cout == 8'h5A) cout_at = i;
      end
      for (int k = 0; k < 4; k++)
        chk($sformatf("R6 mode %0d cell %0d first edge", md, k), 64'(first_nz[k]), 64'(1 + k*(md+1)));
      chk($sformatf("R7 mode %0d cascade edge", md), 64'(cout_at), 64'(4*(md+1)));
    end

    // R8: wrap after 1041 products of 65025
    for (int i = 0; i < 6; i++) step(1, 8'hFF, 1, 8'hFF, 0, 0, 0, 0, "R8 fill");
    step(1, 8'hFF, 1, 8'hFF, 0, 0, 0, 4'hF, "R8");
    for (int i = 0; i < 1040; i++) step(1, 8'hFF, 1, 8'hFF, 0, 0, 0, 0, "R8");
    for (int k = 0; k < 4; k++) chk("R8 wrap", 64'(acc_of(k)), 64'd582161);

    // R6: pseudo-random FIR streams per mode, checked by the scoreboard
    lf = 16'hACE1;
    for (int md = 0; md < 4; md++) begin
      for (int i = 0; i < 48; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(lf[0] | lf[1], lf[15:8], lf[2] | lf[3], lf[7:0] ^ lf[15:8], lf[4], lf[5],
             2'(md), 4'(1 << ((i / (md+1)) % 4)), "R6 random");
      end
    end

    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule